// File: doc/BRIEF.md
# Virtual Interrupt CPU Interface

This block sits between a hypervisor and one guest processor and presents virtual interrupts to the guest. The hypervisor places entries in a small bank of list registers. Each entry holds an interrupt number, a priority, a virtual group and a lifecycle state. The guest then takes and retires these interrupts on its own: an acknowledge returns the number of the most urgent pending entry and marks it active, and an end-of-interrupt retires the matching active entry. The hypervisor is not involved in either step.

Each entry's virtual group selects which line it raises. Group 0 entries drive the virtual FIQ line and group 1 entries drive the virtual IRQ line, whatever group the interrupt had physically. Two mask inputs gate the lines separately. A maintenance output tells the hypervisor when every list register is empty, so that it can queue more work. An end-of-interrupt that names no active entry sets a sticky error flag and changes nothing else.

Top module: `vif_cpu_if`

## Requirements
- R1: After reset every list register is invalid, `virq` and `vfiq` are 0, `maint` is 1, `eoi_err` is 0 and `g_ack_id` reads 1023.
- R2: A hypervisor write (`hv_we`) loads ID, priority, group and state into entry `hv_idx`. States are 0 invalid, 1 pending, 2 active, 3 pending-and-active.
- R3: An acknowledge returns, on `g_ack_id` one cycle later, the ID of the entry in state 1 with the lowest priority value, with the lowest index winning a tie. That entry moves to state 2.
- R4: An acknowledge with no entry in state 1 returns the spurious ID 1023 and leaves all entries unchanged.
- R5: An end-of-interrupt whose ID matches an entry in state 2 or 3 (lowest index first) moves that entry to state 0 from state 2, or to state 1 from state 3.
- R6: An end-of-interrupt that matches no active entry changes no entry and sets `eoi_err`, which stays 1 until reset.
- R7: `vfiq` is 1 while some entry in state 1 has group 0, and `virq` is 1 while some entry in state 1 has group 1. Entries in states 0, 2 and 3 drive neither line.
- R8: `i_mask` forces `virq` to 0 and `f_mask` forces `vfiq` to 0.
- R9: `maint` is 1 exactly when every list register is in state 0.
- R10: When a hypervisor write and a guest acknowledge or end-of-interrupt target the same entry in the same cycle, the write decides that entry's contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hv_we | input | 1 | Hypervisor list register write strobe |
| hv_idx | input | 2 | List register index to write |
| hv_id | input | 10 | Interrupt ID to load |
| hv_prio | input | 5 | Priority to load (lower is more urgent) |
| hv_grp | input | 1 | Virtual group to load (0 FIQ, 1 IRQ) |
| hv_state | input | 2 | State to load |
| g_ack | input | 1 | Guest acknowledge strobe |
| g_ack_id | output | 10 | ID returned by the last acknowledge |
| g_eoi | input | 1 | Guest end-of-interrupt strobe |
| g_eoi_id | input | 10 | ID being retired |
| i_mask | input | 1 | Masks the virtual IRQ line |
| f_mask | input | 1 | Masks the virtual FIQ line |
| virq | output | 1 | Virtual IRQ to the guest |
| vfiq | output | 1 | Virtual FIQ to the guest |
| maint | output | 1 | All list registers empty |
| eoi_err | output | 1 | Sticky unmatched end-of-interrupt flag |

## Verification
The bench sweeps 256 combinations of pending patterns, priorities with forced ties, and groups, then drains each set by repeated acknowledges. This exposes a tie broken toward the higher index, or a comparison that returns the highest priority number instead of the lowest. It then retires every entry and checks the maintenance signal, so an end-of-interrupt that leaves an entry active would keep `maint` low. Other tests cover an entry loaded as pending-and-active. A design that offered such an entry for acknowledge, or cleared it fully on retire, would return the wrong ID. Further tests cover a write colliding with an acknowledge on the same slot, where a wrong priority lets the guest overwrite fresh data. An unmatched end-of-interrupt must leave the active entry in place and latch the error flag.

// File: rtl/vif_pkg.sv
package vif_pkg;
  typedef enum logic [1:0] {
    LR_INV  = 2'd0,
    LR_PEND = 2'd1,
    LR_ACT  = 2'd2,
    LR_PACT = 2'd3
  } lr_state_e;

  function automatic logic is_active(input logic [1:0] s);
    return s[1];
  endfunction
endpackage

// File: rtl/vif_prio_sel.sv
module vif_prio_sel #(
  parameter int NUM_LR = 4,
  parameter int PRI_W  = 5,
  parameter int IDX_W  = 2
) (
  input  logic [NUM_LR-1:0]            elig,
  input  logic [NUM_LR-1:0][PRI_W-1:0] prio,
  output logic                         found,
  output logic [IDX_W-1:0]             idx
);
  logic [PRI_W-1:0] best;

  always_comb begin
    found = 1'b0;
    idx   = '0;
    best  = '1;
    for (int i = 0; i < NUM_LR; i++) begin
      if (elig[i] && (!found || prio[i] < best)) begin
        found = 1'b1;
        best  = prio[i];
        idx   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/vif_lr_bank.sv
module vif_lr_bank import vif_pkg::*; #(
  parameter int NUM_LR = 4,
  parameter int ID_W   = 10,
  parameter int PRI_W  = 5,
  parameter int IDX_W  = 2
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         hv_we,
  input  logic [IDX_W-1:0]             hv_idx,
  input  logic [ID_W-1:0]              hv_id,
  input  logic [PRI_W-1:0]             hv_prio,
  input  logic                         hv_grp,
  input  logic [1:0]                   hv_state,
  input  logic                         ack_do,
  input  logic [IDX_W-1:0]             ack_idx,
  input  logic                         eoi_do,
  input  logic [ID_W-1:0]              eoi_id,
  output logic [NUM_LR-1:0][ID_W-1:0]  lr_id,
  output logic [NUM_LR-1:0][PRI_W-1:0] lr_prio,
  output logic [NUM_LR-1:0]            lr_grp,
  output logic [NUM_LR-1:0][1:0]       lr_st,
  output logic                         eoi_match
);
  logic [IDX_W-1:0] eoi_idx;

  // lowest matching active index wins: scan downward, last hit kept
  always_comb begin
    eoi_match = 1'b0;
    eoi_idx   = '0;
    for (int i = NUM_LR - 1; i >= 0; i--) begin
      if (is_active(lr_st[i]) && lr_id[i] == eoi_id) begin
        eoi_match = 1'b1;
        eoi_idx   = IDX_W'(i);
      end
    end
  end

  for (genvar g = 0; g < NUM_LR; g++) begin : g_lr
    always_ff @(posedge clk) begin
      if (rst) begin
        lr_st[g]   <= LR_INV;
        lr_id[g]   <= '0;
        lr_prio[g] <= '0;
        lr_grp[g]  <= 1'b0;
      end else if (hv_we && hv_idx == IDX_W'(g)) begin
        lr_st[g]   <= hv_state;
        lr_id[g]   <= hv_id;
        lr_prio[g] <= hv_prio;
        lr_grp[g]  <= hv_grp;
      end else if (ack_do && ack_idx == IDX_W'(g)) begin
        lr_st[g] <= LR_ACT;
      end else if (eoi_do && eoi_match && eoi_idx == IDX_W'(g)) begin
        lr_st[g] <= (lr_st[g] == LR_PACT) ? LR_PEND : LR_INV;
      end
    end
  end

  // R2: a write lands in the addressed slot
  a_r2_hv_load: assert property (@(posedge clk) disable iff (rst)
    hv_we |=> lr_id[$past(hv_idx)] == $past(hv_id));

  // R3: acknowledged slot becomes active unless overwritten
  a_r3_ack_to_active: assert property (@(posedge clk) disable iff (rst)
    (ack_do && !(hv_we && hv_idx == ack_idx)) |=> lr_st[$past(ack_idx)] == LR_ACT);

  // R5: retired slot is no longer active
  a_r5_eoi_retires: assert property (@(posedge clk) disable iff (rst)
    (eoi_do && eoi_match && !(hv_we && hv_idx == eoi_idx))
      |=> !is_active(lr_st[$past(eoi_idx)]));
endmodule

// File: rtl/vif_cpu_if.sv
module vif_cpu_if import vif_pkg::*; #(
  parameter int NUM_LR = 4,
  parameter int ID_W   = 10,
  parameter int PRI_W  = 5,
  localparam int IDX_W = (NUM_LR > 1) ? $clog2(NUM_LR) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hv_we,
  input  logic [IDX_W-1:0] hv_idx,
  input  logic [ID_W-1:0]  hv_id,
  input  logic [PRI_W-1:0] hv_prio,
  input  logic             hv_grp,
  input  logic [1:0]       hv_state,
  input  logic             g_ack,
  output logic [ID_W-1:0]  g_ack_id,
  input  logic             g_eoi,
  input  logic [ID_W-1:0]  g_eoi_id,
  input  logic             i_mask,
  input  logic             f_mask,
  output logic             virq,
  output logic             vfiq,
  output logic             maint,
  output logic             eoi_err
);
  localparam logic [ID_W-1:0] SPUR_ID = {ID_W{1'b1}};

  logic [NUM_LR-1:0][ID_W-1:0]  lr_id;
  logic [NUM_LR-1:0][PRI_W-1:0] lr_prio;
  logic [NUM_LR-1:0]            lr_grp;
  logic [NUM_LR-1:0][1:0]       lr_st;
  logic                         eoi_match;
  logic [NUM_LR-1:0]            elig;
  logic [NUM_LR-1:0]            empty;
  logic                         sel_found;
  logic [IDX_W-1:0]             sel_idx;
  logic                         ack_do;

  for (genvar g = 0; g < NUM_LR; g++) begin : g_flags
    assign elig[g]  = (lr_st[g] == LR_PEND);
    assign empty[g] = (lr_st[g] == LR_INV);
  end

  assign ack_do = g_ack && sel_found;

  vif_lr_bank #(
    .NUM_LR(NUM_LR), .ID_W(ID_W), .PRI_W(PRI_W), .IDX_W(IDX_W)
  ) u_bank (
    .clk(clk), .rst(rst),
    .hv_we(hv_we), .hv_idx(hv_idx), .hv_id(hv_id), .hv_prio(hv_prio),
    .hv_grp(hv_grp), .hv_state(hv_state),
    .ack_do(ack_do), .ack_idx(sel_idx),
    .eoi_do(g_eoi), .eoi_id(g_eoi_id),
    .lr_id(lr_id), .lr_prio(lr_prio), .lr_grp(lr_grp), .lr_st(lr_st),
    .eoi_match(eoi_match)
  );

  vif_prio_sel #(
    .NUM_LR(NUM_LR), .PRI_W(PRI_W), .IDX_W(IDX_W)
  ) u_sel (
    .elig(elig), .prio(lr_prio), .found(sel_found), .idx(sel_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      g_ack_id <= SPUR_ID;
      virq     <= 1'b0;
      vfiq     <= 1'b0;
      maint    <= 1'b1;
      eoi_err  <= 1'b0;
    end else begin
      if (g_ack) g_ack_id <= sel_found ? lr_id[sel_idx] : SPUR_ID;
      virq  <= (|(elig & lr_grp)) && !i_mask;
      vfiq  <= (|(elig & ~lr_grp)) && !f_mask;
      maint <= &empty;
      if (g_eoi && !eoi_match) eoi_err <= 1'b1;
    end
  end

  // R4: nothing pending yields the spurious ID
  a_r4_spurious: assert property (@(posedge clk) disable iff (rst)
    (g_ack && !sel_found) |=> g_ack_id == SPUR_ID);

  // R6: error flag never clears outside reset
  a_r6_err_sticky: assert property (@(posedge clk) disable iff (rst)
    eoi_err |=> eoi_err);

  // R8: masks silence their lines
  a_r8_irq_mask: assert property (@(posedge clk) disable iff (rst)
    i_mask |=> !virq);
  a_r8_fiq_mask: assert property (@(posedge clk) disable iff (rst)
    f_mask |=> !vfiq);
endmodule

// File: tb/tb_vif_cpu_if.sv
module tb_vif_cpu_if;
  localparam int CLK_PERIOD = 10;
  localparam int NLR = 4;
  localparam int SPUR = 1023;

  logic       clk = 1'b0;
  logic       rst;
  logic       hv_we;
  logic [1:0] hv_idx;
  logic [9:0] hv_id;
  logic [4:0] hv_prio;
  logic       hv_grp;
  logic [1:0] hv_state;
  logic       g_ack;
  logic [9:0] g_ack_id;
  logic       g_eoi;
  logic [9:0] g_eoi_id;
  logic       i_mask, f_mask;
  logic       virq, vfiq, maint, eoi_err;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;

  int m_st[NLR];
  int m_id[NLR];
  int m_pr[NLR];
  int m_gr[NLR];

  always #(CLK_PERIOD/2) clk = ~clk;

  vif_cpu_if dut (
    .clk(clk), .rst(rst),
    .hv_we(hv_we), .hv_idx(hv_idx), .hv_id(hv_id), .hv_prio(hv_prio),
    .hv_grp(hv_grp), .hv_state(hv_state),
    .g_ack(g_ack), .g_ack_id(g_ack_id),
    .g_eoi(g_eoi), .g_eoi_id(g_eoi_id),
    .i_mask(i_mask), .f_mask(f_mask),
    .virq(virq), .vfiq(vfiq), .maint(maint), .eoi_err(eoi_err)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  task automatic wr(input int idx, input int id, input int pr, input int gr, input int st);
    hv_we = 1; hv_idx = 2'(idx); hv_id = 10'(id); hv_prio = 5'(pr);
    hv_grp = gr[0]; hv_state = 2'(st);
    tick();
    hv_we = 0;
    m_st[idx] = st; m_id[idx] = id; m_pr[idx] = pr; m_gr[idx] = gr;
  endtask

  task automatic ack();
    g_ack = 1; tick(); g_ack = 0;
  endtask

  task automatic eoi(input int id);
    g_eoi = 1; g_eoi_id = 10'(id); tick(); g_eoi = 0;
  endtask

  task automatic clear_all();
    for (int i = 0; i < NLR; i++) wr(i, 0, 0, 0, 0);
  endtask

  function automatic int exp_ack_idx();
    int best = -1;
    for (int i = 0; i < NLR; i++)
      if (m_st[i] == 1 && (best < 0 || m_pr[i] < m_pr[best])) best = i;
    return best;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    n_chk++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    summary();
  end

  initial begin
    rst = 1; hv_we = 0; hv_idx = 0; hv_id = 0; hv_prio = 0; hv_grp = 0; hv_state = 0;
    g_ack = 0; g_eoi = 0; g_eoi_id = 0; i_mask = 0; f_mask = 0;
    for (int i = 0; i < NLR; i++) begin m_st[i] = 0; m_id[i] = 0; m_pr[i] = 0; m_gr[i] = 0; end
    @(negedge clk); tick(); tick();
    rst = 0;
    // R1 reset state
    chk(virq == 0 && vfiq == 0, "R1 lines", {virq, vfiq}, 0);
    chk(maint == 1, "R1 maint", maint, 1);
    chk(eoi_err == 0, "R1 err", eoi_err, 0);
    chk(g_ack_id == SPUR, "R1 ack_id", g_ack_id, SPUR);
    // R4 spurious on empty bank
    ack();
    chk(g_ack_id == SPUR, "R4 empty ack", g_ack_id, SPUR);
    tick();
    chk(maint == 1, "R4 unchanged", maint, 1);

    // R2 R3 R5 R7 R9 sweep
    for (int t = 0; t < 256; t++) begin
      int pend_any = 0;
      int e_irq = 0;
      int e_fiq = 0;
      for (int i = 0; i < NLR; i++) begin
        int p = (t >> i) & 1;
        wr(i, ((t * 4 + i) % 1000) + 1, (((t >> 4) * (i + 1)) + i) % 3, ((t >> 2) + i) & 1, p);
        if (p != 0) begin
          pend_any = 1;
          if (m_gr[i] != 0) e_irq = 1; else e_fiq = 1;
        end
      end
      tick(); tick();
      chk(maint == (pend_any == 0), "R9 maint after fill", maint, pend_any == 0);
      chk(virq == e_irq[0], "R7 virq", virq, e_irq);
      chk(vfiq == e_fiq[0], "R7 vfiq", vfiq, e_fiq);
      for (int k = 0; k <= NLR; k++) begin
        int bi = exp_ack_idx();
        int eid = (bi < 0) ? SPUR : m_id[bi];
        ack();
        chk(g_ack_id == 10'(eid), (bi < 0) ? "R4 spurious" : "R3 ack order", g_ack_id, eid);
        if (bi >= 0) m_st[bi] = 2;
      end
      tick(); tick();
      chk(virq == 0 && vfiq == 0, "R7 active silent", {virq, vfiq}, 0);
      for (int i = NLR - 1; i >= 0; i--) begin
        if (m_st[i] == 2) begin eoi(m_id[i]); m_st[i] = 0; end
      end
      tick(); tick();
      chk(maint == 1, "R5 R9 all retired", maint, 1);
      chk(eoi_err == 0, "R6 no false error", eoi_err, 0);
    end

    // R5 pending-and-active entry
    clear_all();
    wr(2, 50, 3, 1, 3);
    tick(); tick();
    chk(virq == 0, "R7 pact silent", virq, 0);
    ack();
    chk(g_ack_id == SPUR, "R4 pact not eligible", g_ack_id, SPUR);
    eoi(50);
    tick(); tick();
    chk(virq == 1, "R5 pact to pending", virq, 1);
    ack();
    chk(g_ack_id == 50, "R5 pending after retire", g_ack_id, 50);
    eoi(50);
    tick(); tick();
    chk(maint == 1, "R5 final retire", maint, 1);

    // R10 write beats acknowledge on same slot
    wr(0, 7, 1, 1, 1);
    g_ack = 1; hv_we = 1; hv_idx = 0; hv_id = 9; hv_prio = 1; hv_grp = 1; hv_state = 1;
    tick();
    g_ack = 0; hv_we = 0;
    chk(g_ack_id == 7, "R10 ack sees old", g_ack_id, 7);
    ack();
    chk(g_ack_id == 9, "R10 write kept", g_ack_id, 9);
    eoi(9);

    // R8 masks
    clear_all();
    wr(0, 20, 4, 0, 1);
    wr(1, 21, 4, 1, 1);
    tick(); tick();
    chk(virq == 1 && vfiq == 1, "R7 both lines", {virq, vfiq}, 3);
    i_mask = 1; tick(); tick();
    chk(virq == 0, "R8 i_mask", virq, 0);
    chk(vfiq == 1, "R8 i_mask leaves fiq", vfiq, 1);
    i_mask = 0; f_mask = 1; tick(); tick();
    chk(vfiq == 0, "R8 f_mask", vfiq, 0);
    chk(virq == 1, "R8 f_mask leaves irq", virq, 1);
    f_mask = 0;

    // R6 unmatched end-of-interrupt
    clear_all();
    wr(3, 300, 2, 1, 1);
    ack();
    chk(g_ack_id == 300, "R6 setup", g_ack_id, 300);
    eoi(301);
    tick();
    chk(eoi_err == 1, "R6 err set", eoi_err, 1);
    chk(maint == 0, "R6 entry kept", maint, 0);
    eoi(300);
    tick(); tick();
    chk(maint == 1, "R6 entry was still active", maint, 1);
    chk(eoi_err == 1, "R6 err sticky", eoi_err, 1);

    summary();
  end
endmodule